// File: doc/BRIEF.md
# One-Time-Programmable Fuse Word Sequencer

This block controls a small array of one-time-programmable fuse words through a 32-bit register port. Software selects a word address in the control register and then starts one of two operations. A sense read copies the addressed word into a result register. A program operation burns a data word into the addressed location, and it runs only when the control register holds the correct unlock key. Programming can only turn fuse bits from 0 to 1, so a new value is OR-ed into what the word already holds.

Each operation passes through a lead relax phase, a strobe phase and a trail relax phase. The lengths of these phases, in clock cycles, come from the timing register. The array is read or burned only in the last cycle of the strobe phase. While an operation runs, a busy flag reads high. Any rejected request raises a sticky error flag, which software clears by writing a 1 to it through a clear alias of the control register. The array is a behavioural model that resets to all zeros, which stands for a blank part.

Top module: `fuse_ctl`

## Requirements
- R1: After reset, the control register reads 32'h0000_0000 and the timing register reads 32'h0007_1009.
- R2: The control register has the following layout. Bits [31:16] hold the unlock key, bit 9 the sticky error flag, bit 8 the busy flag (read-only), and bits [6:0] the word address. All other bits read 0. Writing offset 8'h00 loads the key and address fields and leaves the error and busy flags unchanged.
- R3: Writing a value with bit 0 set to the sense command register (offset 8'h30) starts a read of the addressed word. When busy falls, the result register (offset 8'h40) holds that word.
- R4: Writing the program data register (offset 8'h20) while the key field equals 16'h3E77 starts a program operation. The operation sets the addressed word to its old value OR-ed with the written data. No bit of a stored word ever returns to 0.
- R5: A program request made while the key field holds any other value does not start. It sets the error flag, leaves busy low, and leaves the array unchanged.
- R6: The timing register holds the read strobe in bits [21:16], the relax value in bits [15:12] and the program strobe in bits [11:0]. Each relax phase lasts relax+1 cycles. The strobe phase lasts strobe − 2·(relax+1) + 1 cycles, and at least 1 cycle. Busy therefore stays high for strobe+2 cycles after the triggering write.
- R7: A request that arrives while busy is high, including in the final busy cycle, sets the error flag and is dropped. The running operation completes with its own address and result.
- R8: A request whose address is not below NUM_WORDS (default 64) sets the error flag and starts nothing.
- R9: The clear alias (offset 8'h08) clears each key, address or error bit that is written as 1 and leaves bits written as 0 unchanged. The set alias (offset 8'h04) ORs the written bits into the key and address fields.
- R10: When a program operation completes, the key field returns to 0. A sense read leaves the key field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte offset of the register written |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte offset of the register read |
| rd_data | output | 32 | Combinational read data for rd_addr |

## Verification
Two events can land in the same clock edge: the completion of a running operation in its final busy cycle, and a new trigger write. The bench counts negedges from the first trigger and places a program write so that its rising edge falls in the last busy cycle. It also places a second trigger in the middle of the strobe window. In both cases the check requires that the new request is dropped, that the error flag is set, that busy falls on schedule, that the first read returns its own word, and that a later read shows the target word unchanged.

// File: rtl/fuse_ctl_pkg.sv
// Package: shared register offsets, field constants and phase encoding
// for the fuse word sequencer. Assumes a byte-addressed register port.
package fuse_ctl_pkg;

    localparam int FUSE_ADDR_W  = 7;
    localparam int STROBE_W     = 12;
    localparam int RELAX_W      = 4;
    localparam int RD_STROBE_W  = 6;

    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_SET    = 8'h04;
    localparam logic [7:0] OFS_CLR    = 8'h08;
    localparam logic [7:0] OFS_TIMING = 8'h10;
    localparam logic [7:0] OFS_PDATA  = 8'h20;
    localparam logic [7:0] OFS_SCMD   = 8'h30;
    localparam logic [7:0] OFS_SDATA  = 8'h40;

    localparam logic [15:0] UNLOCK_KEY = 16'h3E77;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_STROBE,
        PH_TRAIL,
        PH_DONE
    } phase_t;

endpackage

// File: rtl/fuse_phase_timer.sv
// Module: fuse_phase_timer
// Runs one access as lead relax, strobe, trail relax, done.
// Lengths are latched when start is high. The caller must raise start
// only while idle. fire pulses in the last strobe cycle.
module fuse_phase_timer
    import fuse_ctl_pkg::*;
#(
    parameter int SW = STROBE_W,
    parameter int RW = RELAX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [RW-1:0] relax,
    input  logic [SW-1:0] strobe,
    output logic          busy,
    output logic          fire,
    output logic          done
);
    localparam int CNT_W = SW + 2;

    phase_t           phase_q;
    logic [CNT_W-1:0] cnt_q, rl_q, act_q;
    logic [CNT_W-1:0] rl_w, total_w, span_w, act_w;

    // Derive the relax length and the active strobe length, clamped to at least one cycle
    always_comb begin
        rl_w    = CNT_W'(relax) + CNT_W'(1);
        total_w = CNT_W'(strobe) + CNT_W'(1);
        span_w  = rl_w << 1;
        act_w   = (total_w > span_w) ? (total_w - span_w) : CNT_W'(1);
    end

    // Phase sequencer with a down-counter per phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            rl_q    <= '0;
            act_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: if (start) begin
                    phase_q <= PH_LEAD;
                    cnt_q   <= rl_w - CNT_W'(1);
                    rl_q    <= rl_w;
                    act_q   <= act_w;
                end
                PH_LEAD: if (cnt_q == '0) begin
                    phase_q <= PH_STROBE;
                    cnt_q   <= act_q - CNT_W'(1);
                end else cnt_q <= cnt_q - CNT_W'(1);
                PH_STROBE: if (cnt_q == '0) begin
                    phase_q <= PH_TRAIL;
                    cnt_q   <= rl_q - CNT_W'(1);
                end else cnt_q <= cnt_q - CNT_W'(1);
                PH_TRAIL: if (cnt_q == '0) phase_q <= PH_DONE;
                          else cnt_q <= cnt_q - CNT_W'(1);
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy = (phase_q != PH_IDLE);
    assign fire = (phase_q == PH_STROBE) && (cnt_q == '0);
    assign done = (phase_q == PH_DONE);

    // R7: the controller never starts an access while one is running
    a_r7_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (phase_q == PH_IDLE));

    // R6: the done cycle always follows the trail relax phase
    a_r6_done_after_trail: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DONE) |-> ($past(phase_q) == PH_TRAIL));

endmodule

// File: rtl/fuse_bank_array.sv
// Module: fuse_bank_array
// Behavioural fuse storage. A program pulse ORs bits into one word, so bits
// only move from 0 to 1. Reset clears it to model a blank part.
module fuse_bank_array #(
    parameter int NUM_WORDS = 64,
    parameter int WORD_W    = 32,
    parameter int IDX_W     = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pgm_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] pgm_bits,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] mem [NUM_WORDS];

    // Burn selected bits into the indexed word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WORDS; i++) mem[i] <= '0;
        end else if (pgm_en) begin
            mem[idx] <= mem[idx] | pgm_bits;
        end
    end

    assign rd_word = mem[idx];

    // R4: a word seen under a steady index never loses a set bit
    a_r4_bits_never_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(idx)) |-> (($past(rd_word) & ~rd_word) == '0));

endmodule

// File: rtl/fuse_ctl.sv
// Module: fuse_ctl (top)
// Register front end of the fuse sequencer. It holds the control, timing,
// data and result registers, screens triggers, and runs the phase timer and
// fuse array. Assumes one register write per cycle and combinational reads.
module fuse_ctl
    import fuse_ctl_pkg::*;
#(
    parameter int          NUM_WORDS       = 64,
    parameter logic [5:0]  RST_STROBE_READ = 6'd7,
    parameter logic [3:0]  RST_RELAX       = 4'd1,
    parameter logic [11:0] RST_STROBE_PROG = 12'd9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [7:0]  rd_addr,
    output logic [31:0] rd_data
);
    localparam int IDX_W = $clog2(NUM_WORDS);
    localparam logic [FUSE_ADDR_W:0] WORD_LIMIT = (FUSE_ADDR_W+1)'(NUM_WORDS);

    logic [15:0]            key_q;
    logic [FUSE_ADDR_W-1:0] addr_q;
    logic                   err_q;
    logic [RD_STROBE_W-1:0] t_sread_q;
    logic [RELAX_W-1:0]     t_relax_q;
    logic [STROBE_W-1:0]    t_sprog_q;
    logic [31:0]            pdata_q, sense_q;
    logic [IDX_W-1:0]       op_idx_q;
    logic                   op_prog_q;

    logic busy, fire, done;
    logic prog_trig, read_trig, trig, reject, start;
    logic [STROBE_W-1:0] sel_strobe;
    logic [31:0] rd_word;

    // Decode triggers and decide whether a request may start
    always_comb begin
        prog_trig  = wr_en && (wr_addr == OFS_PDATA);
        read_trig  = wr_en && (wr_addr == OFS_SCMD) && wr_data[0];
        trig       = prog_trig || read_trig;
        reject     = busy || ({1'b0, addr_q} >= WORD_LIMIT) ||
                     (prog_trig && (key_q != UNLOCK_KEY));
        start      = trig && !reject;
        sel_strobe = prog_trig ? t_sprog_q : STROBE_W'(t_sread_q);
    end

    // Control register fields, aliases, sticky error and key clear on program completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q  <= '0;
            addr_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (trig && reject) err_q <= 1'b1;
            if (wr_en) begin
                case (wr_addr)
                    OFS_CTRL: begin
                        key_q  <= wr_data[31:16];
                        addr_q <= wr_data[FUSE_ADDR_W-1:0];
                    end
                    OFS_SET: begin
                        key_q  <= key_q | wr_data[31:16];
                        addr_q <= addr_q | wr_data[FUSE_ADDR_W-1:0];
                    end
                    OFS_CLR: begin
                        key_q  <= key_q & ~wr_data[31:16];
                        addr_q <= addr_q & ~wr_data[FUSE_ADDR_W-1:0];
                        if (wr_data[9]) err_q <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (done && op_prog_q) key_q <= '0;
        end
    end

    // Timing register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_sread_q <= RST_STROBE_READ;
            t_relax_q <= RST_RELAX;
            t_sprog_q <= RST_STROBE_PROG;
        end else if (wr_en && (wr_addr == OFS_TIMING)) begin
            t_sread_q <= wr_data[21:16];
            t_relax_q <= wr_data[15:12];
            t_sprog_q <= wr_data[11:0];
        end
    end

    // Latch the operation context at start and capture sense data at the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_idx_q  <= '0;
            op_prog_q <= 1'b0;
            pdata_q   <= '0;
            sense_q   <= '0;
        end else begin
            if (start) begin
                op_idx_q  <= addr_q[IDX_W-1:0];
                op_prog_q <= prog_trig;
                if (prog_trig) pdata_q <= wr_data;
            end
            if (fire && !op_prog_q) sense_q <= rd_word;
        end
    end

    fuse_phase_timer #(.SW(STROBE_W), .RW(RELAX_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .relax  (t_relax_q),
        .strobe (sel_strobe),
        .busy   (busy),
        .fire   (fire),
        .done   (done)
    );

    fuse_bank_array #(.NUM_WORDS(NUM_WORDS), .WORD_W(32), .IDX_W(IDX_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .pgm_en   (fire && op_prog_q),
        .idx      (op_idx_q),
        .pgm_bits (pdata_q),
        .rd_word  (rd_word)
    );

    // Register read multiplexer
    always_comb begin
        case (rd_addr)
            OFS_CTRL:   rd_data = {key_q, 5'b0, 1'b0, err_q, busy, 1'b0, addr_q};
            OFS_TIMING: rd_data = {10'b0, t_sread_q, t_relax_q, t_sprog_q};
            OFS_PDATA:  rd_data = pdata_q;
            OFS_SDATA:  rd_data = sense_q;
            default:    rd_data = '0;
        endcase
    end

    // R5: a keyless program request from idle leaves busy low and flags error
    a_r5_bad_key_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_trig && !busy && (key_q != UNLOCK_KEY)) |=> (err_q && !busy));

    // R7: any trigger while busy flags error
    a_r7_busy_trigger_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && busy) |=> err_q);

    // R8: an out-of-range address flags error
    a_r8_range_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && ({1'b0, addr_q} >= WORD_LIMIT)) |=> err_q);

    // R10: the key field is empty after a program completes
    a_r10_key_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_prog_q) |=> (key_q == '0));

endmodule

// File: tb/fuse_ctl_tb.sv
// Scoreboard bench: driver tasks push expected sense words to a queue; a
// monitor pops and compares them when each sense read completes.
module fuse_ctl_tb;
    import fuse_ctl_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit mon_go = 1'b0;
    logic [31:0] exp_q[$];

    always #4 clk = ~clk;  // 125 MHz

    fuse_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0; rd_addr = OFS_CTRL; #1;
        while (rd_data[8] && cyc < 5000) begin
            @(negedge clk); #1; cyc++;
        end
    endtask

    task automatic hand_to_monitor();
        rd_addr = OFS_SDATA;
        mon_go = 1'b1;
        wait (mon_go == 1'b0);
    endtask

    task automatic do_sense(input logic [6:0] a, input logic [31:0] exp, input int exp_cyc);
        int c;
        exp_q.push_back(exp);
        bus_wr(OFS_CTRL, {16'h0, 9'h0, a});
        bus_wr(OFS_SCMD, 32'h1);
        wait_idle(c);
        check("R6 sense busy cycles", c, exp_cyc);
        hand_to_monitor();
    endtask

    task automatic do_prog(input logic [6:0] a, input logic [31:0] d, input int exp_cyc);
        int c;
        logic [31:0] v;
        bus_wr(OFS_CTRL, {UNLOCK_KEY, 9'h0, a});
        bus_wr(OFS_PDATA, d);
        wait_idle(c);
        check("R6 program busy cycles", c, exp_cyc);
        peek(OFS_CTRL, v);
        check("R10 key cleared after program", v, {16'h0, 9'h0, a});
    endtask

    // Monitor: compare each completed sense result with the scoreboard head (R3)
    initial begin
        logic [31:0] got, expv;
        forever begin
            wait (mon_go == 1'b1);
            #1;
            got  = rd_data;
            expv = exp_q.pop_front();
            check("R3 sense result", got, expv);
            mon_go = 1'b0;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Driver
    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        peek(OFS_CTRL, v);   check("R1 control reset", v, 32'h0);
        peek(OFS_TIMING, v); check("R1 timing reset", v, 32'h0007_1009);

        // Default timing: read strobe 7 -> 9 busy cycles, program strobe 9 -> 11
        do_sense(7'd5, 32'h0, 9);
        do_prog(7'd5, 32'h0000_00A5, 11);
        do_sense(7'd5, 32'h0000_00A5, 9);
        do_prog(7'd5, 32'h0F00_0F00, 11);
        do_sense(7'd5, 32'h0F00_0FA5, 9);   // R4 bits OR-ed

        // R5 wrong key
        bus_wr(OFS_CTRL, {16'h1234, 9'h0, 7'd5});
        bus_wr(OFS_PDATA, 32'hFFFF_FFFF);
        peek(OFS_CTRL, v);
        check("R5 wrong key: error set, busy low", v, 32'h1234_0205);
        do_sense(7'd5, 32'h0F00_0FA5, 9);   // R5 array unchanged; R2 direct write keeps error

        peek(OFS_CTRL, v);
        check("R2 error kept by direct control write", v, 32'h0000_0205);

        // R9 aliases
        bus_wr(OFS_CLR, 32'h0000_0200);
        peek(OFS_CTRL, v); check("R9 clear alias drops only error", v, 32'h0000_0005);
        bus_wr(OFS_SET, 32'h3E77_0000);
        peek(OFS_CTRL, v); check("R9 set alias ORs key", v, 32'h3E77_0005);
        bus_wr(OFS_CLR, 32'hFFFF_0000);
        peek(OFS_CTRL, v); check("R9 clear alias drops key", v, 32'h0000_0005);

        // R8 out-of-range address
        bus_wr(OFS_CTRL, 32'h0000_0046);
        bus_wr(OFS_SCMD, 32'h1);
        peek(OFS_CTRL, v); check("R8 range error, no busy", v, 32'h0000_0246);
        bus_wr(OFS_CLR, 32'h0000_0200);

        // R6 new timing: read 20, relax 3, program 30
        bus_wr(OFS_TIMING, 32'h0014_301E);
        peek(OFS_TIMING, v); check("R6 timing readback", v, 32'h0014_301E);
        do_sense(7'd9, 32'h0, 22);
        do_prog(7'd9, 32'h8000_0001, 32);
        do_sense(7'd9, 32'h8000_0001, 22);

        // R7 collisions: mid-strobe trigger and a trigger in the final busy cycle
        exp_q.push_back(32'h8000_0001);
        bus_wr(OFS_CTRL, {UNLOCK_KEY, 9'h0, 7'd9});
        bus_wr(OFS_SCMD, 32'h1);                 // now at negedge 1
        repeat (4) @(negedge clk);
        bus_wr(OFS_SCMD, 32'h1);                 // edge 5, rejected
        peek(OFS_CTRL, v);
        check("R7 mid-run trigger flags error, busy kept", v & 32'h300, 32'h300);
        repeat (16) @(negedge clk);              // negedge 22, last busy cycle
        bus_wr(OFS_PDATA, 32'hFFFF_FFFF);
        peek(OFS_CTRL, v);
        check("R7 final-cycle trigger dropped; R10 read keeps key", v, 32'h3E77_0209);
        hand_to_monitor();
        bus_wr(OFS_CLR, 32'h0000_0200);
        do_sense(7'd9, 32'h8000_0001, 22);       // R7 array untouched

        check("R3 scoreboard drained", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule